// File: doc/BRIEF.md
# UART Receiver with Line Status

This block is the receive half of an asynchronous serial port. It recovers 8-bit characters from a serial line, sampled once per pulse of a 16x oversampling enable, with an optional even parity bit, and stores them either in a single holding register or in a small receive FIFO. A five-bit status word reports whether data is waiting, and flags overrun, parity errors, framing errors and line breaks.

Software, or a bus adapter placed in front of the block, pops characters with a one-cycle data read strobe and acknowledges errors with a one-cycle status read strobe. In FIFO mode every stored character carries its own error flags. The status word shows the flags of the character at the head of the queue, so an error becomes visible only when the damaged character is the next one to be read.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset all five status bits are 0 and the line is treated as idle (high).
- R2: A frame is one low start bit, eight data bits sent LSB first, an optional parity bit and one stop bit, each lasting 16 oversample ticks. A completed character appears on `rx_data` and sets status bit 0 (data ready). In holding-register mode, a data read strobe clears bit 0.
- R3: The start bit is checked again on the 8th oversample tick after the falling edge. If the line is high by then, the low pulse is ignored and no character is stored.
- R4: With `par_en` high, even parity is checked (the XOR of the data bits and the parity bit must be 0), and a mismatch sets status bit 2. With `par_en` low, no parity bit is expected and bit 2 is never set by a data character.
- R5: A stop bit sampled low stores the character with status bit 3 (framing error). The receiver then treats that low stop bit as a validated start bit and samples the next eight data bits from it.
- R6: A line that is low for a full character time (start, data, parity if enabled, and stop) stores one character 0x00 with status bits 4 (break), 3 and 2 all set. No further character is stored until the line has gone high again.
- R7: A status read strobe clears status bits 1, 2 and 3. Bits 0 and 4 are not affected.
- R8: In holding-register mode, a character that completes while the previous one is unread overwrites it and sets status bit 1 (overrun).
- R9: In FIFO mode (depth `DEPTH`, default 4), a character that completes while the FIFO is full is discarded, the stored characters are kept, and status bit 1 is set.
- R10: In FIFO mode, status bits 2, 3 and 4 show the flags of the character at the head of the FIFO. Bit 0 clears when the last entry is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| par_en | input | 1 | Expect and check an even parity bit |
| fifo_en | input | 1 | 1 selects the receive FIFO, 0 selects the single holding register; change only while empty |
| rbr_rd | input | 1 | Data read strobe, pops the head character |
| lsr_rd | input | 1 | Status read strobe, clears bits 1 to 3 |
| rx_data | output | 8 | Head character (holding register or FIFO head) |
| lsr | output | 5 | Status: bit 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break |

## Verification
A bit counter or tick phase that slips shows up as a corrupted byte on `rx_data`, or as a spurious framing flag at the end of the same frame. A fault in the occupancy count or the pointers shows up as a wrong data-ready bit in the cycle after the push or pop. It also shows up as a wrong character, or the wrong flags, after a later read strobe. Stale head-flag tracking is visible right after a status read or a data read, because bits 2 to 4 must follow the new head character within one cycle.

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr #(
  parameter int DEPTH = 4,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic       par_en,
  input  logic       fifo_en,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  output logic [7:0] rx_data,
  output logic [4:0] lsr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(OVS);
  localparam int EW = 11;
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [AW:0]   CAP  = (AW + 1)'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  logic [1:0]    sync;
  logic          rxs;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    shr;
  logic          pbit, allz;

  assign rxs = sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      shr  <= '0;
      pbit <= 1'b0;
      allz <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE:
          if (!rxs) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == MID) begin
            cnt <= '0;
            if (!rxs) begin
              st   <= S_DATA;
              bitn <= '0;
              allz <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_DATA: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            shr  <= {rxs, shr[7:1]};
            allz <= allz & ~rxs;
            bitn <= bitn + 1'b1;
            if (bitn == 3'd7) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            pbit <= rxs;
            allz <= allz & ~rxs;
            st   <= S_STOP;
          end
        end
        S_STOP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            if (rxs)       st <= S_IDLE;
            else if (allz) st <= S_BRK;
            else begin
              st   <= S_DATA;
              bitn <= '0;
              allz <= 1'b1;
            end
          end
        end
        S_BRK:
          if (rxs) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic          push, brk_now;
  logic [EW-1:0] wword;

  assign push    = (st == S_STOP) && tick16 && (cnt == LAST);
  assign brk_now = ~rxs & allz;
  assign wword   = {brk_now, ~rxs, brk_now | (par_en & (^shr ^ pbit)),
                    brk_now ? 8'h00 : shr};

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [AW:0]   count;
  logic          empty, full, pop, acc, ovw, ovr_evt, head_chg;
  logic          oe, hclr;
  logic [EW-1:0] head;

  assign empty    = (count == '0);
  assign full     = fifo_en ? (count == CAP) : !empty;
  assign pop      = rbr_rd && !empty;
  assign acc      = push && (!full || pop);
  assign ovr_evt  = push && full && !pop;
  assign ovw      = ovr_evt && !fifo_en;
  assign head_chg = pop || (acc && empty) || ovw;

  always_ff @(posedge clk)
    if (acc)      mem[wp] <= wword;
    else if (ovw) mem[rp] <= wword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
      oe    <= 1'b0;
      hclr  <= 1'b0;
    end else begin
      if (acc) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      case ({acc, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovr_evt)     oe <= 1'b1;
      else if (lsr_rd) oe <= 1'b0;
      if (head_chg)    hclr <= 1'b0;
      else if (lsr_rd) hclr <= 1'b1;
    end
  end

  assign head    = mem[rp];
  assign rx_data = head[7:0];
  assign lsr     = {head[10] & ~empty,
                    head[9]  & ~empty & ~hclr,
                    head[8]  & ~empty & ~hclr,
                    oe,
                    ~empty};
endmodule

module uart_rx_lsr_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rbr_rd,
  input logic                       lsr_rd,
  input logic                       fifo_en,
  input logic [4:0]                 lsr,
  input logic [$clog2(DEPTH):0]     count,
  input logic                       push,
  input logic                       ovr_evt
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lsr == 5'b0);

  p_oe_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !ovr_evt |=> !lsr[1]);

  p_oe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[1] && !lsr_rd |=> lsr[1]);

  p_dr_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd && count == 1 && !push |=> !lsr[0]);

  p_fifo_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && count == DEPTH && !rbr_rd |=> count == DEPTH);

  p_single_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> count <= 1);
endmodule

bind uart_rx_lsr uart_rx_lsr_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
  .fifo_en(fifo_en), .lsr(lsr), .count(count), .push(push),
  .ovr_evt(ovr_evt)
);

// File: tb/uart_rx_lsr_test.sv
module uart_rx_lsr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       tick16 = 1'b0;
  logic       par_en = 1'b0;
  logic       fifo_en = 1'b0;
  logic       rbr_rd = 1'b0;
  logic       lsr_rd = 1'b0;
  logic [7:0] rx_data;
  logic [4:0] lsr;
  logic [1:0] div = 2'd0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  uart_rx_lsr uut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
    .par_en(par_en), .fifo_en(fifo_en), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .rx_data(rx_data), .lsr(lsr)
  );

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    div    <= div + 2'd1;
    tick16 <= (div == 2'd2);
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, int clocks = 64);
    rx_in = b;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic use_par, logic pb, logic stop);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (use_par) send_bit(pb);
    send_bit(stop);
  endtask

  task automatic pulse_rd();
    rbr_rd = 1'b1;
    @(negedge clk);
    rbr_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_lsr();
    lsr_rd = 1'b1;
    @(negedge clk);
    lsr_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status after reset", {3'b0, lsr}, 8'h00);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R2 data", rx_data, 8'hA5);
    chk("R2 data ready", {3'b0, lsr}, 8'h01);
    pulse_rd();
    chk("R2 read clears ready", {3'b0, lsr}, 8'h00);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    chk("R2 second data", rx_data, 8'h3C);
    pulse_rd();
  endtask

  task automatic t_glitch();
    send_bit(1'b0, 12);
    send_bit(1'b1, 64 * 12);
    chk("R3 glitch ignored", {3'b0, lsr}, 8'h00);
  endtask

  task automatic t_parity();
    par_en = 1'b1;
    send_frame(8'h3C, 1'b1, ^8'h3C, 1'b1);
    chk("R4 good parity", {3'b0, lsr}, 8'h01);
    pulse_rd();
    send_frame(8'h01, 1'b1, 1'b0, 1'b1);
    chk("R4 parity error", {3'b0, lsr}, 8'h05);
    chk("R4 data kept", rx_data, 8'h01);
    pulse_lsr();
    chk("R7 status read clears parity", {3'b0, lsr}, 8'h01);
    pulse_rd();
    par_en = 1'b0;
    send_frame(8'h01, 1'b0, 1'b0, 1'b1);
    chk("R4 no check when disabled", {3'b0, lsr}, 8'h01);
    pulse_rd();
  endtask

  task automatic t_framing();
    logic [7:0] nxt = 8'h0F;
    send_frame(8'h55, 1'b0, 1'b0, 1'b0);
    rx_in = nxt[0];
    chk("R5 framing flag", {3'b0, lsr}, 8'h09);
    chk("R5 data", rx_data, 8'h55);
    pulse_rd();
    repeat (62) @(negedge clk);
    for (int i = 1; i < 8; i++) send_bit(nxt[i]);
    send_bit(1'b1);
    chk("R5 resync data", rx_data, 8'h0F);
    chk("R5 resync status", {3'b0, lsr}, 8'h01);
    pulse_rd();
  endtask

  task automatic t_break();
    send_bit(1'b0, 64 * 11);
    chk("R6 break status", {3'b0, lsr}, 8'h1D);
    chk("R6 break data", rx_data, 8'h00);
    pulse_lsr();
    chk("R7 break bit kept", {3'b0, lsr}, 8'h11);
    pulse_rd();
    send_bit(1'b0, 64 * 20);
    chk("R6 one break per low period", {3'b0, lsr}, 8'h00);
    send_bit(1'b1, 64 * 2);
    chk("R6 idle after release", {3'b0, lsr}, 8'h00);
  endtask

  task automatic t_overrun_hold();
    send_frame(8'h11, 1'b0, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R8 overwrite", rx_data, 8'h22);
    chk("R8 overrun flag", {3'b0, lsr}, 8'h03);
    pulse_lsr();
    chk("R7 status read clears overrun", {3'b0, lsr}, 8'h01);
    pulse_rd();
    chk("R8 empty after read", {3'b0, lsr}, 8'h00);
  endtask

  task automatic t_fifo();
    fifo_en = 1'b1;
    par_en  = 1'b1;
    send_frame(8'h10, 1'b1, ^8'h10, 1'b1);
    send_frame(8'h20, 1'b1, ~^8'h20, 1'b1);
    send_frame(8'h30, 1'b1, ^8'h30, 1'b1);
    send_frame(8'h40, 1'b1, ^8'h40, 1'b1);
    send_frame(8'h50, 1'b1, ^8'h50, 1'b1);
    chk("R9 head kept", rx_data, 8'h10);
    chk("R9 overrun with clean head", {3'b0, lsr}, 8'h03);
    pulse_lsr();
    chk("R7 overrun cleared", {3'b0, lsr}, 8'h01);
    pulse_rd();
    chk("R10 second entry", rx_data, 8'h20);
    chk("R10 flag at head", {3'b0, lsr}, 8'h05);
    pulse_rd();
    chk("R10 third entry", rx_data, 8'h30);
    chk("R10 clean head", {3'b0, lsr}, 8'h01);
    pulse_rd();
    chk("R9 fourth entry", rx_data, 8'h40);
    pulse_rd();
    chk("R10 ready clears when empty", {3'b0, lsr}, 8'h00);
    fifo_en = 1'b0;
    par_en  = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_framing();
    t_break();
    t_overrun_hold();
    t_fifo();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule